// File: doc/BRIEF.md
# Cubic Luminance Transform Engine

This block reshapes the brightness of every pixel in a frame to lower the power an emissive panel draws while sharpening contrast. It does this with a cubic curve on luminance that has no constant term. The curve's three coefficients are rebuilt for each frame from that frame's average luminance. Each coefficient is a straight line in the average. Its slope and offset are supplied on input ports, which are trained offline.

Each frame crosses the pixel port twice. On the first crossing (gather) the block converts each RGB pixel to YCbCr, sums the luminance and counts the pixels. It produces no output. After the last pixel it divides the sum by the count over a fixed number of cycles (solve) and latches the three coefficients. On the second crossing (apply) it evaluates the curve on each pixel's luminance in nested form. It then recombines the new luminance with the untouched chroma, converts the result back to RGB and outputs it one cycle later with its frame markers. Coefficients are signed Q4.8 with `CW` = 12 bits. Luminance is treated as a Q0.8 fraction.

Top module: `ltx_engine`

## Requirements
- R1: While reset (`rst_ni` low, asynchronous) is applied and right after it, `mode_o` reads 0 (gather) and `out_valid_o` is 0.
- R2: `mode_o` encodes 0 = gather, 1 = solve, 2 = apply; 3 never occurs. In gather, accepted pixels produce no output. A pixel accepted with `pix_eof_i` high moves the block to solve on the next cycle.
- R3: Forward conversion, where >>8 is a floor division by 256: Y = (77R+150G+29B)>>8, Cb = ((128B−43R−85G)>>8)+128, Cr = ((128R−107G−21B)>>8)+128.
- R4: The frame statistic is m = floor(ΣY / N) over the pixels accepted in gather. A pixel with `pix_sof_i` high restarts the sum and the count with itself, so earlier pixels without a start marker are discarded. N must stay below 2^`CNT_W`.
- R5: Solve lasts exactly `CNT_W`+9 cycles (25 by default). While it lasts, pixel inputs, markers included, are ignored: nothing is output and the mode sequence is unchanged.
- R6: At the end of solve each coefficient ak (k = 1, 2, 3) becomes floor(slopek·m/256)+offsetk, saturated to the signed `CW`-bit range [−2048, 2047]. Slopes and offsets are signed Q4.8.
- R7: The new luminance is Y' = ((((a3·Y)>>8 + a2)·Y)>>8 + a1)·Y >> 8, with every >>8 a floor. The result is saturated to 0..255.
- R8: Inverse conversion with dCb = Cb−128 and dCr = Cr−128: R = Y'+((359·dCr)>>8), G = Y'−((88·dCb+183·dCr)>>8), B = Y'+((454·dCb)>>8), each saturated to 0..255.
- R9: An apply-mode pixel accepted at one clock edge appears on the output after that edge, with `out_valid_o` high and its start and end markers copied. Output is valid only for such pixels.
- R10: The coefficients change only at the end of solve. Changes to slope or offset ports at any other time have no effect on the apply pass already under way.
- R11: A pixel accepted in apply with `pix_eof_i` high returns the block to gather.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_valid_i | input | 1 | Input pixel present this cycle |
| pix_sof_i | input | 1 | First pixel of a pass |
| pix_eof_i | input | 1 | Last pixel of a pass |
| pix_r_i | input | 8 | Input red |
| pix_g_i | input | 8 | Input green |
| pix_b_i | input | 8 | Input blue |
| slope3_i | input | CW | Cubic coefficient slope, signed Q4.8 |
| offs3_i | input | CW | Cubic coefficient offset, signed Q4.8 |
| slope2_i | input | CW | Square coefficient slope, signed Q4.8 |
| offs2_i | input | CW | Square coefficient offset, signed Q4.8 |
| slope1_i | input | CW | Linear coefficient slope, signed Q4.8 |
| offs1_i | input | CW | Linear coefficient offset, signed Q4.8 |
| mode_o | output | 2 | Current phase: 0 gather, 1 solve, 2 apply |
| out_valid_o | output | 1 | Output pixel present |
| out_sof_o | output | 1 | Start marker of output pixel |
| out_eof_o | output | 1 | End marker of output pixel |
| out_r_o | output | 8 | Output red |
| out_g_o | output | 8 | Output green |
| out_b_o | output | 8 | Output blue |

## Verification
The main transform is exercised on frames that each isolate one part of the pipeline:
- An identity curve (a1 = 1.0) exposes only the rounding of the two colour conversions.
- An S-shaped cubic with a negative a3 exercises the signed nested evaluation.
- A curve whose a1 falls with the average shows that the gathered statistic reaches the coefficients.
- A gain of 4.0 and a gain of −1.0 drive the output clamp to 255 and to 0.
- A pair of saturating cubic slope and offset values shows whether the coefficient clamps or wraps.

Pure grays separate curve errors from conversion errors, since they pass through both conversions unchanged. Saturated primaries stress the chroma clamp. Stray pixels before the start marker, pixels during solve and port changes during apply each show whether state that ought to hold still is disturbed.

// File: rtl/ltx_pkg.sv
package ltx_pkg;

    typedef enum logic [1:0] {
        MODE_GATHER = 2'd0,
        MODE_SOLVE  = 2'd1,
        MODE_APPLY  = 2'd2
    } ltx_mode_e;

    typedef struct packed {
        logic [7:0] r;
        logic [7:0] g;
        logic [7:0] b;
    } ltx_rgb_t;

    typedef struct packed {
        logic [7:0] y;
        logic [7:0] cb;
        logic [7:0] cr;
    } ltx_ycc_t;

    // Clamp a signed intermediate to an 8-bit pixel code
    function automatic logic [7:0] ltx_sat8(input logic signed [31:0] v);
        if (v < 32'sd0) begin
            return 8'd0;
        end else if (v > 32'sd255) begin
            return 8'd255;
        end
        return 8'(v);
    endfunction

endpackage

// File: rtl/ltx_rgb2ycc.sv
module ltx_rgb2ycc
    import ltx_pkg::*;
(
    input  ltx_rgb_t pix_i,
    output ltx_ycc_t ycc_o
);
    logic signed [31:0] r_s, g_s, b_s;
    logic signed [31:0] y_acc, cb_acc, cr_acc;

    always_comb begin
        r_s    = $signed({24'd0, pix_i.r});
        g_s    = $signed({24'd0, pix_i.g});
        b_s    = $signed({24'd0, pix_i.b});
        // luma weights sum to 256, so a gray input maps to itself
        y_acc  = 32'sd77 * r_s + 32'sd150 * g_s + 32'sd29 * b_s;
        cb_acc = ((32'sd128 * b_s - 32'sd43 * r_s - 32'sd85 * g_s) >>> 8) + 32'sd128;
        cr_acc = ((32'sd128 * r_s - 32'sd107 * g_s - 32'sd21 * b_s) >>> 8) + 32'sd128;
        ycc_o.y  = ltx_sat8(y_acc >>> 8);
        ycc_o.cb = ltx_sat8(cb_acc);
        ycc_o.cr = ltx_sat8(cr_acc);
    end
endmodule

// File: rtl/ltx_ycc2rgb.sv
module ltx_ycc2rgb
    import ltx_pkg::*;
(
    input  ltx_ycc_t ycc_i,
    output ltx_rgb_t pix_o
);
    logic signed [31:0] y_s, dcb, dcr;

    always_comb begin
        y_s = $signed({24'd0, ycc_i.y});
        dcb = $signed({24'd0, ycc_i.cb}) - 32'sd128;
        dcr = $signed({24'd0, ycc_i.cr}) - 32'sd128;
        pix_o.r = ltx_sat8(y_s + ((32'sd359 * dcr) >>> 8));
        pix_o.g = ltx_sat8(y_s - ((32'sd88 * dcb + 32'sd183 * dcr) >>> 8));
        pix_o.b = ltx_sat8(y_s + ((32'sd454 * dcb) >>> 8));
    end
endmodule

// File: rtl/ltx_cubic.sv
// Nested evaluation of a3*y^3 + a2*y^2 + a1*y on a Q0.8 luminance.
// CW must stay at or below 20 so every product fits 32 bits.
module ltx_cubic
    import ltx_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic [7:0]           y_i,
    input  logic signed [CW-1:0] c3_i,
    input  logic signed [CW-1:0] c2_i,
    input  logic signed [CW-1:0] c1_i,
    output logic [7:0]           y_o
);
    logic signed [31:0] y_s, c3_s, c2_s, c1_s;
    logic signed [31:0] step1, step2, step3;

    always_comb begin
        y_s   = $signed({24'd0, y_i});
        c3_s  = 32'(c3_i);
        c2_s  = 32'(c2_i);
        c1_s  = 32'(c1_i);
        step1 = ((c3_s * y_s) >>> 8) + c2_s;
        step2 = ((step1 * y_s) >>> 8) + c1_s;
        step3 = (step2 * y_s) >>> 8;
        y_o   = ltx_sat8(step3);
    end
endmodule

// File: rtl/ltx_div.sv
// Restoring divider: one quotient bit per cycle, NUM_W cycles per division.
module ltx_div #(
    parameter int NUM_W = 24,
    parameter int DEN_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [NUM_W-1:0] quo_o
);
    localparam int STEP_W = $clog2(NUM_W);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_W - 1);

    typedef struct packed {
        logic              busy;
        logic              done;
        logic [STEP_W-1:0] step;
        logic [DEN_W-1:0]  rem;
        logic [DEN_W-1:0]  den;
        logic [NUM_W-1:0]  quo;
    } div_state_t;

    div_state_t s_d, s_q;
    logic [DEN_W:0] trial;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        trial    = {s_q.rem, s_q.quo[NUM_W-1]};
        if (start_i) begin
            s_d.busy = 1'b1;
            s_d.step = '0;
            s_d.rem  = '0;
            s_d.den  = den_i;
            s_d.quo  = num_i;
        end else if (s_q.busy) begin
            if (trial >= {1'b0, s_q.den}) begin
                s_d.rem = DEN_W'(trial - {1'b0, s_q.den});
                s_d.quo = {s_q.quo[NUM_W-2:0], 1'b1};
            end else begin
                s_d.rem = DEN_W'(trial);
                s_d.quo = {s_q.quo[NUM_W-2:0], 1'b0};
            end
            s_d.step = s_q.step + 1'b1;
            if (s_q.step == LAST_STEP) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o = s_q.busy;
    assign done_o = s_q.done;
    assign quo_o  = s_q.quo;

    // R5: a started division is busy on the next cycle
    p_start_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> busy_o);
    // R5: completion is a single-cycle pulse
    p_done_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);
    // R5: busy ends only with a completion
    p_busy_ends_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> done_o);
endmodule

// File: rtl/ltx_engine.sv
module ltx_engine
    import ltx_pkg::*;
#(
    parameter int CW    = 12,
    parameter int CNT_W = 16
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 pix_valid_i,
    input  logic                 pix_sof_i,
    input  logic                 pix_eof_i,
    input  logic [7:0]           pix_r_i,
    input  logic [7:0]           pix_g_i,
    input  logic [7:0]           pix_b_i,
    input  logic signed [CW-1:0] slope3_i,
    input  logic signed [CW-1:0] offs3_i,
    input  logic signed [CW-1:0] slope2_i,
    input  logic signed [CW-1:0] offs2_i,
    input  logic signed [CW-1:0] slope1_i,
    input  logic signed [CW-1:0] offs1_i,
    output logic [1:0]           mode_o,
    output logic                 out_valid_o,
    output logic                 out_sof_o,
    output logic                 out_eof_o,
    output logic [7:0]           out_r_o,
    output logic [7:0]           out_g_o,
    output logic [7:0]           out_b_o
);
    localparam int SUM_W = CNT_W + 8;
    localparam logic signed [31:0] CMAX = (32'sd1 <<< (CW - 1)) - 32'sd1;
    localparam logic signed [31:0] CMIN = -CMAX - 32'sd1;

    typedef struct packed {
        ltx_mode_e        mode;
        logic [SUM_W-1:0] sum;
        logic [CNT_W-1:0] cnt;
        logic [CW-1:0]    c3;
        logic [CW-1:0]    c2;
        logic [CW-1:0]    c1;
        logic             ov;
        logic             osof;
        logic             oeof;
        ltx_rgb_t         opix;
    } eng_state_t;

    eng_state_t s_d, s_q;

    ltx_rgb_t         in_pix, new_pix;
    ltx_ycc_t         in_ycc, new_ycc;
    logic [7:0]       new_y;
    logic             div_start, div_busy, div_done;
    logic [SUM_W-1:0] div_quo;
    logic [7:0]       frame_mean;

    // floor(slope*m/256) + offset, clamped to the signed coefficient range
    function automatic logic [CW-1:0] coef_of(input logic signed [CW-1:0] slope,
                                              input logic signed [CW-1:0] offs,
                                              input logic [7:0] m);
        logic signed [31:0] t;
        t = ((32'(slope) * $signed({24'd0, m})) >>> 8) + 32'(offs);
        if (t > CMAX) begin
            return CW'(CMAX);
        end else if (t < CMIN) begin
            return CW'(CMIN);
        end
        return CW'(t);
    endfunction

    assign in_pix = '{r: pix_r_i, g: pix_g_i, b: pix_b_i};

    ltx_rgb2ycc u_fwd (
        .pix_i (in_pix),
        .ycc_o (in_ycc)
    );

    ltx_cubic #(.CW(CW)) u_curve (
        .y_i  (in_ycc.y),
        .c3_i ($signed(s_q.c3)),
        .c2_i ($signed(s_q.c2)),
        .c1_i ($signed(s_q.c1)),
        .y_o  (new_y)
    );

    assign new_ycc = '{y: new_y, cb: in_ycc.cb, cr: in_ycc.cr};

    ltx_ycc2rgb u_inv (
        .ycc_i (new_ycc),
        .pix_o (new_pix)
    );

    ltx_div #(.NUM_W(SUM_W), .DEN_W(CNT_W)) u_mean (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (div_start),
        .num_i   (s_d.sum),
        .den_i   (s_d.cnt),
        .busy_o  (div_busy),
        .done_o  (div_done),
        .quo_o   (div_quo)
    );

    // the quotient never exceeds 255 because every summand is at most 255
    assign frame_mean = 8'(div_quo);

    always_comb begin
        s_d       = s_q;
        s_d.ov    = 1'b0;
        s_d.osof  = 1'b0;
        s_d.oeof  = 1'b0;
        div_start = 1'b0;
        unique case (s_q.mode)
            MODE_GATHER: begin
                if (pix_valid_i) begin
                    if (pix_sof_i) begin
                        s_d.sum = SUM_W'(in_ycc.y);
                        s_d.cnt = CNT_W'(1);
                    end else begin
                        s_d.sum = s_q.sum + SUM_W'(in_ycc.y);
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                    if (pix_eof_i) begin
                        s_d.mode  = MODE_SOLVE;
                        div_start = 1'b1;
                    end
                end
            end
            MODE_SOLVE: begin
                if (div_done) begin
                    s_d.c3   = coef_of(slope3_i, offs3_i, frame_mean);
                    s_d.c2   = coef_of(slope2_i, offs2_i, frame_mean);
                    s_d.c1   = coef_of(slope1_i, offs1_i, frame_mean);
                    s_d.mode = MODE_APPLY;
                end
            end
            MODE_APPLY: begin
                if (pix_valid_i) begin
                    s_d.ov   = 1'b1;
                    s_d.osof = pix_sof_i;
                    s_d.oeof = pix_eof_i;
                    s_d.opix = new_pix;
                    if (pix_eof_i) begin
                        s_d.mode = MODE_GATHER;
                    end
                end
            end
            default: s_d.mode = MODE_GATHER;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q      <= '0;
            s_q.mode <= MODE_GATHER;
        end else begin
            s_q <= s_d;
        end
    end

    assign mode_o      = s_q.mode;
    assign out_valid_o = s_q.ov;
    assign out_sof_o   = s_q.osof;
    assign out_eof_o   = s_q.oeof;
    assign out_r_o     = s_q.opix.r;
    assign out_g_o     = s_q.opix.g;
    assign out_b_o     = s_q.opix.b;

    // R2: only the three defined phase codes appear
    p_mode_legal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.mode inside {MODE_GATHER, MODE_SOLVE, MODE_APPLY});
    // R2: the last gathered pixel starts solve
    p_gather_to_solve_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.mode == MODE_GATHER && pix_valid_i && pix_eof_i) |=> (s_q.mode == MODE_SOLVE));
    // R5: solve is never left before the divider reports completion
    p_solve_waits_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.mode == MODE_SOLVE && !div_done) |=> (s_q.mode == MODE_SOLVE));
    // R9: output only follows an accepted apply-mode pixel
    p_out_only_apply_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_valid_o |-> ($past(s_q.mode == MODE_APPLY) && $past(pix_valid_i)));
    // R10: coefficients move only on a cycle that leaves solve
    p_coef_stable_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.mode != MODE_SOLVE) |=> $stable({s_q.c3, s_q.c2, s_q.c1}));
    // R11: the last applied pixel returns to gather
    p_apply_to_gather_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.mode == MODE_APPLY && pix_valid_i && pix_eof_i) |=> (s_q.mode == MODE_GATHER));
endmodule

// File: tb/ltx_engine_test.sv
module ltx_engine_test;
    localparam int CW        = 12;
    localparam int CNT_W     = 16;
    localparam int SOLVE_CYC = CNT_W + 9;
    localparam int NF        = 6;

    // per frame: four pixels {R,G,B}
    localparam logic [23:0] FR_PIX [0:NF-1][0:3] = '{
        '{24'h0A0A0A, 24'h808080, 24'hFF0000, 24'h12C07F},
        '{24'h282828, 24'h808080, 24'hC8C8C8, 24'hFFFFFF},
        '{24'h204060, 24'hC0A080, 24'hFFFFFF, 24'h000000},
        '{24'h101010, 24'h505050, 24'hFF00FF, 24'h00FF00},
        '{24'h404040, 24'h0000FF, 24'hFFFF00, 24'h7F7F7F},
        '{24'h282828, 24'h404040, 24'hFFFFFF, 24'hFFFFFF}
    };
    // per frame: slope3, offs3, slope2, offs2, slope1, offs1 (signed Q4.8)
    localparam logic [11:0] FR_PRM [0:NF-1][0:5] = '{
        '{12'h000, 12'h000, 12'h000, 12'h000, 12'h000, 12'h100},
        '{12'h000, 12'hE00, 12'h000, 12'h300, 12'h000, 12'h000},
        '{12'h000, 12'h000, 12'h000, 12'h000, 12'hF00, 12'h180},
        '{12'h000, 12'h000, 12'h000, 12'h000, 12'h000, 12'h400},
        '{12'h000, 12'h000, 12'h000, 12'h000, 12'h000, 12'hF00},
        '{12'h7FF, 12'h7FF, 12'h000, 12'h000, 12'h000, 12'h100}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pix_valid = 1'b0, pix_sof = 1'b0, pix_eof = 1'b0;
    logic [7:0] pix_r = '0, pix_g = '0, pix_b = '0;
    logic [11:0] prm [0:5] = '{default: '0};
    logic [1:0] mode;
    logic out_valid, out_sof, out_eof;
    logic [7:0] out_r, out_g, out_b;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    ltx_engine #(.CW(CW), .CNT_W(CNT_W)) uut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .pix_valid_i (pix_valid),
        .pix_sof_i   (pix_sof),
        .pix_eof_i   (pix_eof),
        .pix_r_i     (pix_r),
        .pix_g_i     (pix_g),
        .pix_b_i     (pix_b),
        .slope3_i    (prm[0]),
        .offs3_i     (prm[1]),
        .slope2_i    (prm[2]),
        .offs2_i     (prm[3]),
        .slope1_i    (prm[4]),
        .offs1_i     (prm[5]),
        .mode_o      (mode),
        .out_valid_o (out_valid),
        .out_sof_o   (out_sof),
        .out_eof_o   (out_eof),
        .out_r_o     (out_r),
        .out_g_o     (out_g),
        .out_b_o     (out_b)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int fl8(input int v);
        return v >>> 8;
    endfunction
    function automatic int sat(input int v, input int lo, input int hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction
    function automatic int s12(input logic [11:0] v);
        return int'($signed(v));
    endfunction
    function automatic int lum(input logic [23:0] p);
        return fl8(77 * int'(p[23:16]) + 150 * int'(p[15:8]) + 29 * int'(p[7:0]));
    endfunction
    function automatic int chb(input logic [23:0] p);
        return fl8(128 * int'(p[7:0]) - 43 * int'(p[23:16]) - 85 * int'(p[15:8])) + 128;
    endfunction
    function automatic int chr(input logic [23:0] p);
        return fl8(128 * int'(p[23:16]) - 107 * int'(p[15:8]) - 21 * int'(p[7:0])) + 128;
    endfunction
    function automatic int coef(input int s, input int o, input int m);
        return sat(fl8(s * m) + o, -2048, 2047);
    endfunction
    function automatic logic [23:0] expect_pix(input logic [23:0] p, input int a3,
                                               input int a2, input int a1);
        int y, u1, u2, yn, dcb, dcr, r, g, b;
        y   = lum(p);
        u1  = fl8(a3 * y) + a2;
        u2  = fl8(u1 * y) + a1;
        yn  = sat(fl8(u2 * y), 0, 255);
        dcb = chb(p) - 128;
        dcr = chr(p) - 128;
        r   = sat(yn + fl8(359 * dcr), 0, 255);
        g   = sat(yn - fl8(88 * dcb + 183 * dcr), 0, 255);
        b   = sat(yn + fl8(454 * dcb), 0, 255);
        return {8'(r), 8'(g), 8'(b)};
    endfunction

    task automatic drive(input logic v, input logic s, input logic e, input logic [23:0] p);
        @(negedge clk);
        pix_valid = v;
        pix_sof   = s;
        pix_eof   = e;
        {pix_r, pix_g, pix_b} = p;
    endtask

    task automatic settle();
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        finish_run();
    end

    initial begin
        int mean, n, a3, a2, a1;
        logic [23:0] got, want;
        repeat (3) @(posedge clk);
        #1;
        chk(mode == 2'd0, "R1 mode in reset", int'(mode), 0);
        chk(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        settle();
        chk(mode == 2'd0, "R1 mode after reset", int'(mode), 0);

        for (int f = 0; f < NF; f++) begin
            @(negedge clk);
            for (int k = 0; k < 6; k++) prm[k] = FR_PRM[f][k];
            // R4: stray bright pixels before the start marker must be dropped
            if (f == 3) begin
                for (int k = 0; k < 2; k++) begin
                    drive(1'b1, 1'b0, 1'b0, 24'hFFFFFF);
                    settle();
                end
            end
            mean = 0;
            for (int i = 0; i < 4; i++) begin
                drive(1'b1, i == 0, i == 3, FR_PIX[f][i]);
                settle();
                chk(out_valid == 1'b0, "R2 no output in gather", int'(out_valid), 0);
                mean += lum(FR_PIX[f][i]);
            end
            mean = mean / 4;
            chk(mode == 2'd1, "R2 eof enters solve", int'(mode), 1);

            // R5: solve length; frame 2 floods the inputs during solve
            n = 0;
            while (mode != 2'd2 && n < 100) begin
                drive(f == 2, 1'b1, 1'b1, 24'hFFFFFF);
                settle();
                n++;
                if (out_valid) chk(1'b0, "R5 output during solve", 1, 0);
            end
            chk(n == SOLVE_CYC, "R5 solve cycles", n, SOLVE_CYC);

            a3 = coef(s12(FR_PRM[f][0]), s12(FR_PRM[f][1]), mean);
            a2 = coef(s12(FR_PRM[f][2]), s12(FR_PRM[f][3]), mean);
            a1 = coef(s12(FR_PRM[f][4]), s12(FR_PRM[f][5]), mean);

            for (int i = 0; i < 4; i++) begin
                drive(1'b1, i == 0, i == 3, FR_PIX[f][i]);
                // R10: port changes in the middle of apply must not matter
                if (f == 1 && i == 1) begin
                    for (int k = 0; k < 6; k++) prm[k] = 12'h5A5 + 12'(k);
                end
                settle();
                want = expect_pix(FR_PIX[f][i], a3, a2, a1);
                got  = {out_r, out_g, out_b};
                // R3 R6 R7 R8 pixel value; frame 5 covers R6 clamp, frames 3-4 R7 clamp
                chk(got == want, (f == 1 && i > 1) ? "R10 held coefficients" :
                    ((f == 5) ? "R6 coefficient saturation" : "R7 R8 transformed pixel"),
                    int'(got), int'(want));
                chk(out_valid && out_sof == (i == 0) && out_eof == (i == 3),
                    "R9 valid and markers", int'({out_valid, out_sof, out_eof}),
                    int'({1'b1, i == 0, i == 3}));
            end
            chk(mode == 2'd0, "R11 back to gather", int'(mode), 0);
            drive(1'b0, 1'b0, 1'b0, 24'h000000);
            settle();
            chk(out_valid == 1'b0, "R9 no output when idle", int'(out_valid), 0);
        end

        // R3: a gray pixel under identity maps to itself exactly (Y=gray, chroma=128)
        @(negedge clk);
        for (int k = 0; k < 6; k++) prm[k] = (k == 5) ? 12'h100 : 12'h000;
        drive(1'b1, 1'b1, 1'b1, 24'h5C5C5C);
        settle();
        n = 0;
        while (mode != 2'd2 && n < 100) begin
            drive(1'b0, 1'b0, 1'b0, 24'h0);
            settle();
            n++;
        end
        drive(1'b1, 1'b1, 1'b1, 24'h5C5C5C);
        settle();
        chk({out_r, out_g, out_b} == 24'h5C5C5C, "R3 gray identity",
            int'({out_r, out_g, out_b}), 32'h5C5C5C);
        drive(1'b0, 1'b0, 1'b0, 24'h0);
        settle();

        finish_run();
    end
endmodule